// File: doc/BRIEF.md
# Ready-Edge Interrupt Unit

This unit watches the ready/busy line of a flash device and tells the host when a long operation has ended. The line is low while the device is busy and high when it is ready. The unit brings the line into the clock domain through a synchroniser and records a ready event each time the line goes from busy to ready. It raises a level interrupt to the host when a recorded event is enabled.

The host sees two byte-wide registers through a simple write strobe, a one-bit address and a combinational read path. The status register (address 0) holds four event bits, which are cleared by writing ones to them. Its top bit reads back the live, synchronised busy level. The mask register (address 1) holds a global enable in bit 7 and per-source enables in bits 3:0. The usual flow is:

1. Clear the status bits with 0x0F.
2. Arm the interrupt with 0x81.
3. Wait for the interrupt.
4. Disarm the interrupt by writing 0x00 to the mask register.

Top module: `ready_edge_irq`

## Requirements
- R1: A low-to-high change on `rb_n_i` passes through a two-flop synchroniser and sets status bit 0 at the third rising clock edge after the change. The edge detector produces a one-cycle pulse.
- R2: A high-to-low change on `rb_n_i` (the device entering busy) sets no status bit.
- R3: Status register bit 7 reads 1 while the synchronised line is low (busy) and 0 while it is high. It follows the line two clock edges after a change, and writes do not affect it.
- R4: Writing to address 0 clears each status bit in 3:0 whose write-data bit is 1 and leaves the bits written with 0 unchanged. Writing 0x0F clears all four bits.
- R5: When a ready event arrives in the same cycle as a write that clears status bit 0, the bit stays set.
- R6: A write to address 1 stores bit 7 as the global enable and bits 3:0 as the source enables. A read of address 1 returns those bits with bits 6:4 as zero, so writing 0x81 reads back 0x81.
- R7: `irq_o` equals the global enable ANDed with the OR of (status bit AND source enable) over bits 3:0. Writing 0x00 to the mask deasserts it immediately after that write edge.
- R8: Events are latched in the status register whatever the mask is. A masked event raises `irq_o` as soon as the mask enables it.
- R9: After reset the status bits, the mask and `irq_o` are all zero. The synchroniser starts in the ready state, so a line that is high at reset release produces no event.
- R10: Status bits 3:1 have no source and read zero. Status bits 6:4 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rb_n_i | input | 1 | Asynchronous ready/busy line from the flash (low = busy) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 = status, 1 = mask |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register (combinational) |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The assertions check the following on every cycle:
- the edge detector never produces a pulse longer than one cycle;
- a ready event always lands in status bit 0 at the next edge, even when a clear is written at the same time;
- a clear with no competing event empties bit 0;
- the status bits hold when there is neither a write nor an event;
- a zero mask write drops the interrupt at the next cycle.

Only the bench scenarios can show the rest: the exact three-edge latency from the pin, the absence of an event on busy entry or after reset, the timing of the busy bit, the mask readback with its zero bits, and a late unmask raising the interrupt for an event that was already latched.

// File: rtl/rdyint_pkg.sv
package rdyint_pkg;
    localparam int DATA_W  = 8;
    localparam int NUM_SRC = 4;
    localparam int SYNC_N  = 2;

    typedef enum logic {
        ADDR_STAT = 1'b0,
        ADDR_MASK = 1'b1
    } reg_addr_e;
endpackage

// File: rtl/rdyint_rb_sync.sv
module rdyint_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_n_i,
    output logic busy_o,
    output logic rise_o
);
    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], rb_n_i};
        s_d.prev  = s_q.chain[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;              // start in the ready state
        end else begin
            s_q <= s_d;
        end
    end

    assign rise_o = s_q.chain[TOP] & ~s_q.prev;
    assign busy_o = ~s_q.chain[TOP];

    // R1: the edge detector emits a single-cycle pulse
    p_rise_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/rdyint_regs.sv
module rdyint_regs
    import rdyint_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int DW   = DATA_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] event_i,
    input  logic            busy_i,
    input  logic            wr_en_i,
    input  logic            addr_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [DW-1:0]   rdata_o,
    output logic            irq_o
);
    localparam int PAD = DW - 1 - NSRC;

    typedef struct packed {
        logic [NSRC-1:0] stat;
        logic            gen_en;
        logic [NSRC-1:0] src_en;
    } regs_t;

    regs_t           r_d, r_q;
    logic            stat_wr;
    logic            mask_wr;
    logic [NSRC-1:0] clr;
    logic            unused_wdata;

    assign unused_wdata = ^wdata_i[DW-2:NSRC];

    always_comb begin
        r_d     = r_q;
        stat_wr = wr_en_i && (addr_i == ADDR_STAT);
        mask_wr = wr_en_i && (addr_i == ADDR_MASK);
        clr     = stat_wr ? wdata_i[NSRC-1:0] : '0;
        // an incoming event wins over a clear in the same cycle
        r_d.stat = (r_q.stat & ~clr) | event_i;
        if (mask_wr) begin
            r_d.gen_en = wdata_i[DW-1];
            r_d.src_en = wdata_i[NSRC-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign irq_o = r_q.gen_en && (|(r_q.stat & r_q.src_en));

    always_comb begin
        if (addr_i == ADDR_STAT) begin
            rdata_o = {busy_i, {PAD{1'b0}}, r_q.stat};
        end else begin
            rdata_o = {r_q.gen_en, {PAD{1'b0}}, r_q.src_en};
        end
    end

    // R5: an event is always recorded, even against a clear
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        event_i[0] |=> r_q.stat[0]);

    // R4: a clear with no competing event empties the bit
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_STAT && wdata_i[0] && !event_i[0]) |=> !r_q.stat[0]);

    // R4: status holds without a write or an event
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && event_i == '0) |=> $stable(r_q.stat));

    // R7: a zero mask write drops the interrupt at once
    p_mask_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_MASK && wdata_i == '0) |=> !irq_o);
endmodule

// File: rtl/ready_edge_irq.sv
module ready_edge_irq
    import rdyint_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rb_n_i,
    input  logic              reg_wr_i,
    input  logic              reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    logic               busy;
    logic               rise;
    logic [NUM_SRC-1:0] events;

    rdyint_rb_sync #(.STAGES(SYNC_N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rb_n_i (rb_n_i),
        .busy_o (busy),
        .rise_o (rise)
    );

    // only bit 0 has a source; the rest stay empty
    assign events = {{(NUM_SRC-1){1'b0}}, rise};

    rdyint_regs #(.NSRC(NUM_SRC), .DW(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_i (events),
        .busy_i  (busy),
        .wr_en_i (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .irq_o   (irq_o)
    );
endmodule

// File: tb/tb_ready_edge_irq.sv
`timescale 1ns/1ps
module tb_ready_edge_irq;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       rb_n = 1;
    logic       wr = 0;
    logic       addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;   // 100 MHz

    ready_edge_irq dut (
        .clk(clk), .rst_n(rst_n), .rb_n_i(rb_n), .reg_wr_i(wr),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    // behavioural reference: history of line samples, newest first
    bit         hist[$];
    logic [3:0] m_stat;
    bit         m_gen;
    logic [3:0] m_src;

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist   = '{1, 1, 1};
            m_stat = 0;
            m_gen  = 0;
            m_src  = 0;
        end else begin
            bit   rise;
            logic [3:0] clr;
            rise = hist[1] && !hist[2];
            clr  = (wr && addr == 1'b0) ? wdata[3:0] : 4'h0;
            m_stat = (m_stat & ~clr) | {3'b000, rise};
            if (wr && addr == 1'b1) begin
                m_gen = wdata[7];
                m_src = wdata[3:0];
            end
            hist.push_front(rb_n);
            void'(hist.pop_back());
        end
    end

    // cycle-by-cycle comparison, away from both clock edges
    always begin
        @(posedge clk);
        #2;
        if (rst_n) begin
            chk("R7 irq", {7'b0, irq}, {7'b0, m_gen && |(m_stat & m_src)});
            if (addr == 1'b0)
                chk("R3/R4/R10 status", rdata, {!hist[1], 3'b000, m_stat});
            else
                chk("R6 mask", rdata, {m_gen, 3'b000, m_src});
        end
    end

    task automatic wr_reg(bit a, logic [7:0] d);
        addr = a; wdata = d; wr = 1;
        @(negedge clk);
        wr = 0; addr = 0;
    endtask

    task automatic rd_chk(string tag, bit a, logic [7:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
        addr = 0;
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1;
        wait_n(5);
        // R9: clean reset state, no event from a high line
        rd_chk("R9 status after reset", 1'b0, 8'h00);
        rd_chk("R9 mask after reset", 1'b1, 8'h00);
        chk("R9 irq after reset", {7'b0, irq}, 8'h00);

        // R2/R3: entering busy sets only the live bit
        rb_n = 0;
        @(negedge clk);
        rd_chk("R3 busy not yet visible after one edge", 1'b0, 8'h00);
        @(negedge clk);
        rd_chk("R3 busy visible after two edges", 1'b0, 8'h80);
        wait_n(3);
        rd_chk("R2 no event on busy entry", 1'b0, 8'h80);

        // R1: latency of the ready event; R8: latched while masked
        rb_n = 1;
        wait_n(2);
        rd_chk("R1 no event after two edges", 1'b0, 8'h00);
        @(negedge clk);
        rd_chk("R1 event after third edge", 1'b0, 8'h01);
        chk("R8 masked event no irq", {7'b0, irq}, 8'h00);

        // R6/R7/R8: unmask raises irq for the pending event
        wr_reg(1'b1, 8'h81);
        chk("R8 irq after unmask", {7'b0, irq}, 8'h01);
        rd_chk("R6 mask readback 0x81", 1'b1, 8'h81);
        wr_reg(1'b1, 8'h00);
        chk("R7 irq off after zero mask", {7'b0, irq}, 8'h00);
        wr_reg(1'b1, 8'hF1);
        rd_chk("R6 unused mask bits read zero", 1'b1, 8'h81);
        wr_reg(1'b1, 8'h01);
        chk("R7 no irq without global enable", {7'b0, irq}, 8'h00);
        wr_reg(1'b1, 8'h81);

        // R4/R10: selective and full clear
        wr_reg(1'b0, 8'h0E);
        rd_chk("R4 zero bit keeps status", 1'b0, 8'h01);
        rd_chk("R10 unsourced bits zero", 1'b0, 8'h01);
        wr_reg(1'b0, 8'h0F);
        rd_chk("R4 full clear", 1'b0, 8'h00);
        chk("R4 irq off after clear", {7'b0, irq}, 8'h00);

        // R5: event meets clear in the same cycle
        rb_n = 0;
        wait_n(4);
        rb_n = 1;
        wait_n(2);
        wr_reg(1'b0, 8'h0F);
        rd_chk("R5 set wins over clear", 1'b0, 8'h01);
        chk("R5 irq stays", {7'b0, irq}, 8'h01);
        wr_reg(1'b0, 8'h0F);

        // assorted line patterns, checked against the model each cycle
        for (int k = 0; k < 40; k++) begin
            rb_n = (k % 7 == 0) || (k % 3 == 1);
            if (k % 11 == 5) wr_reg(1'b0, 8'h01);
            else @(negedge clk);
        end
        rb_n = 1;
        wait_n(5);
        wr_reg(1'b1, 8'h00);
        chk("R7 disarm at end", {7'b0, irq}, 8'h00);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule